// File: doc/BRIEF.md
# Stream-Detecting Hardware Prefetcher

This block sits beside a cache and observes its demand accesses. It keeps a small, fully associative table of candidate address streams. An entry starts out unused. A demand access that no entry claims allocates an entry, which then trains on the direction of nearby accesses. Two nearby accesses that agree on a direction confirm the stream, and the entry then monitors a start/end window of cache blocks.

While an entry monitors, any access that falls strictly inside its window causes the block to issue a burst of prefetch block addresses beyond the window's far end. The window then advances in the stream direction. It grows while its span stays within the distance limit and slides once the span would exceed that limit. When the table is full, the least recently used entry is reclaimed.

Prefetch addresses leave one per cycle on a valid/ready port. Demand accesses are accepted only between bursts.

Top module: `stream_prefetcher`

## Requirements
- R1: After reset `acc_ready` is 1, `pf_valid` is 0, and the table holds no stream, so no single access can cause a prefetch.
- R2: The low log2(BLK_BYTES) address bits (bits [5:0] with 64-byte blocks) are dropped before any comparison. Every `pf_addr` has those bits at 0.
- R3: A training entry claims any access within DIST/2 blocks of its allocation block. The first claimed access records its direction (higher = ascending, lower = descending). A second, agreeing access turns the entry into a monitor with start = allocation block and end = access block + DEGREE (ascending) or − DEGREE (descending). Training never emits prefetches.
- R4: If the second direction sample disagrees with the first, the entry goes back to unused with all of its fields cleared.
- R5: An ascending monitor is hit only when start < block < end, both bounds strict. A hit emits exactly DEGREE prefetches, end+1 up to end+DEGREE in block units, in increasing order.
- R6: After a hit, end moves DEGREE blocks in the stream direction. If |new end − start| > DIST, start also moves DEGREE blocks (slide). Otherwise start stays where it is (grow).
- R7: A descending monitor is hit when end < block < start and emits end−1 down to end−DEGREE, in that order.
- R8: Prefetches leave one per accepted `pf_valid`/`pf_ready` beat. `pf_addr` holds steady while stalled. `acc_ready` stays 0 from the cycle after an accepting hit until the last beat is taken.
- R9: An access that no entry claims allocates the lowest-index unused entry, or else reclaims the entry with recency rank ENTRIES−1. The claimed or allocated entry gets rank 0, and every entry ranked below its old rank moves down one.
- R10: An access to exactly the allocation block of a training entry refreshes that entry's recency but records no direction sample.
- R11: When several entries claim an access, only the lowest-index one acts on it, and nothing is allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Demand access present |
| acc_ready | output | 1 | Block can take a demand access (no burst pending) |
| acc_addr | input | ADDR_W | Demand byte address |
| pf_valid | output | 1 | Prefetch address present |
| pf_ready | input | 1 | Consumer takes the prefetch address |
| pf_addr | output | ADDR_W | Block-aligned prefetch byte address |

## Verification
The hardest situation to reach from the ports is recency-based replacement in a full table. It needs eight live entries whose ranks have been reshuffled, and whether an entry was evicted shows only indirectly, through whether a later access trains it into a stream. The bench fills every entry with far-apart regions, touches the oldest one, and forces a reclaim. It then proves which entry survived: a prefetch burst appears for the surviving stream, and none appears where the evicted entry's history would have produced one. The bench runs with DIST=13 so that both the growing and the sliding window are reached. Backpressure is held while an access waits at the input, to show that the access is not taken mid-burst.

// File: rtl/spf_pkg.sv
package spf_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TRAIN = 2'd1,
        ST_MON   = 2'd2
    } slot_state_e;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;
endpackage

// File: rtl/spf_entry_match.sv
// Decides whether one table entry claims the current block and which
// direction the block lies in relative to the entry's allocation block.
module spf_entry_match
    import spf_pkg::*;
#(
    parameter int BW   = 26,
    parameter int HALF = 2
) (
    input  slot_state_e     st,
    input  dir_e            dir,
    input  logic [BW-1:0]   alloc,
    input  logic [BW-1:0]   tail,
    input  logic [BW-1:0]   head,
    input  logic [BW-1:0]   blk,
    output logic            hit,
    output dir_e            sample
);
    logic [BW-1:0] dist_abs;
    logic          train_hit;
    logic          up_hit;
    logic          down_hit;

    always_comb begin
        dist_abs  = (blk >= alloc) ? (blk - alloc) : (alloc - blk);
        train_hit = (st == ST_TRAIN) && (dist_abs <= BW'(HALF));
        up_hit    = (dir == DIR_UP)   && (tail < blk) && (blk < head);
        down_hit  = (dir == DIR_DOWN) && (head < blk) && (blk < tail);
        hit       = train_hit || ((st == ST_MON) && (up_hit || down_hit));
        if (blk == alloc)     sample = DIR_NONE;
        else if (blk > alloc) sample = DIR_UP;
        else                  sample = DIR_DOWN;
    end
endmodule

// File: rtl/spf_pick.sv
// Priority selection: lowest-index claiming entry, and the allocation
// victim (lowest-index unused entry, else the oldest by rank).
module spf_pick #(
    parameter int N  = 8,
    parameter int IW = 3
) (
    input  logic [N-1:0]    hit,
    input  logic [N-1:0]    free,
    input  logic [N*IW-1:0] ranks,
    output logic            any_hit,
    output logic [IW-1:0]   hit_idx,
    output logic [IW-1:0]   victim_idx
);
    always_comb begin
        any_hit    = |hit;
        hit_idx    = '0;
        victim_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hit[i]) hit_idx = IW'(i);
        end
        for (int i = N - 1; i >= 0; i--) begin
            if (ranks[i*IW +: IW] == IW'(N - 1)) victim_idx = IW'(i);
        end
        if (|free) begin
            for (int i = N - 1; i >= 0; i--) begin
                if (free[i]) victim_idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/spf_burst.sv
// Emits DEGREE consecutive block numbers, one per accepted beat.
module spf_burst #(
    parameter int BW     = 26,
    parameter int DEGREE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld,
    input  logic [BW-1:0] base,
    input  logic          up,
    input  logic          ready,
    output logic          valid,
    output logic [BW-1:0] blk
);
    localparam int CW = $clog2(DEGREE + 1);

    typedef struct packed {
        logic [CW-1:0] left;
        logic          up;
        logic [BW-1:0] nxt;
    } bst_t;

    bst_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d.left = CW'(DEGREE);
            st_d.up   = up;
            st_d.nxt  = up ? (base + BW'(1)) : (base - BW'(1));
        end else if ((st_q.left != '0) && ready) begin
            st_d.left = st_q.left - CW'(1);
            st_d.nxt  = st_q.up ? (st_q.nxt + BW'(1)) : (st_q.nxt - BW'(1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = (st_q.left != '0);
    assign blk   = st_q.nxt;
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher
    import spf_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int ENTRIES   = 8,
    parameter int DEGREE    = 4,
    parameter int DIST      = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    output logic              acc_ready,
    input  logic [ADDR_W-1:0] acc_addr,
    output logic              pf_valid,
    input  logic              pf_ready,
    output logic [ADDR_W-1:0] pf_addr
);
    localparam int OFS_W = $clog2(BLK_BYTES);
    localparam int BW    = ADDR_W - OFS_W;
    localparam int RW    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam int HALF  = DIST / 2;

    typedef struct packed {
        slot_state_e   st;
        dir_e          dir;
        dir_e          s0;
        logic [BW-1:0] alloc;
        logic [BW-1:0] tail;
        logic [BW-1:0] head;
        logic [RW-1:0] rank;
    } slot_t;

    typedef struct packed {
        slot_t [ENTRIES-1:0] slot;
    } tbl_t;

    function automatic tbl_t tbl_init();
        tbl_t t;
        t = '0;
        for (int i = 0; i < ENTRIES; i++) t.slot[i].rank = RW'(i);
        return t;
    endfunction

    tbl_t tbl_d, tbl_q;

    logic [BW-1:0]      acc_blk;
    logic               acc_fire;
    logic               unused_ofs;
    logic [ENTRIES-1:0] hit_v;
    logic [ENTRIES-1:0] free_v;
    logic [ENTRIES*RW-1:0] rank_flat;
    dir_e               smp [ENTRIES];
    logic               any_hit;
    logic [RW-1:0]      hit_idx;
    logic [RW-1:0]      victim_idx;
    logic [RW-1:0]      sel;
    slot_t              cur;
    slot_t              nxt;
    dir_e               smp_sel;
    logic               cur_up;
    logic [BW-1:0]      new_head;
    logic [BW-1:0]      span;
    logic               ld;
    logic [BW-1:0]      ld_base;
    logic               ld_up;
    logic               busy;
    logic [BW-1:0]      pf_blk;

    assign acc_blk    = acc_addr[ADDR_W-1:OFS_W];
    assign unused_ofs = ^acc_addr[OFS_W-1:0];
    assign acc_ready  = !busy;
    assign acc_fire   = acc_valid && acc_ready;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        spf_entry_match #(.BW(BW), .HALF(HALF)) u_match (
            .st     (tbl_q.slot[g].st),
            .dir    (tbl_q.slot[g].dir),
            .alloc  (tbl_q.slot[g].alloc),
            .tail   (tbl_q.slot[g].tail),
            .head   (tbl_q.slot[g].head),
            .blk    (acc_blk),
            .hit    (hit_v[g]),
            .sample (smp[g])
        );
        assign free_v[g]                = (tbl_q.slot[g].st == ST_IDLE);
        assign rank_flat[g*RW +: RW]    = tbl_q.slot[g].rank;
    end

    spf_pick #(.N(ENTRIES), .IW(RW)) u_pick (
        .hit        (hit_v),
        .free       (free_v),
        .ranks      (rank_flat),
        .any_hit    (any_hit),
        .hit_idx    (hit_idx),
        .victim_idx (victim_idx)
    );

    always_comb begin
        tbl_d    = tbl_q;
        sel      = any_hit ? hit_idx : victim_idx;
        cur      = tbl_q.slot[sel];
        nxt      = cur;
        smp_sel  = smp[sel];
        cur_up   = (cur.dir == DIR_UP);
        new_head = cur_up ? (cur.head + BW'(DEGREE)) : (cur.head - BW'(DEGREE));
        span     = cur_up ? (new_head - cur.tail) : (cur.tail - new_head);
        ld       = 1'b0;
        ld_base  = cur.head;
        ld_up    = cur_up;

        if (acc_fire) begin
            if (any_hit && (cur.st == ST_MON)) begin
                // confirmed stream: fire a burst and advance the window
                ld       = 1'b1;
                nxt.head = new_head;
                if (span > BW'(DIST)) begin
                    nxt.tail = cur_up ? (cur.tail + BW'(DEGREE)) : (cur.tail - BW'(DEGREE));
                end
            end else if (any_hit) begin
                // training entry: collect direction samples
                if (smp_sel != DIR_NONE) begin
                    if (cur.s0 == DIR_NONE) begin
                        nxt.s0 = smp_sel;
                    end else if (smp_sel == cur.s0) begin
                        nxt.st   = ST_MON;
                        nxt.dir  = smp_sel;
                        nxt.tail = cur.alloc;
                        nxt.head = (smp_sel == DIR_UP) ? (acc_blk + BW'(DEGREE))
                                                       : (acc_blk - BW'(DEGREE));
                    end else begin
                        nxt = '0;
                    end
                end
            end else begin
                // nobody claims the access: (re)allocate the chosen victim
                nxt       = '0;
                nxt.st    = ST_TRAIN;
                nxt.alloc = acc_blk;
            end

            for (int j = 0; j < ENTRIES; j++) begin
                if (tbl_q.slot[j].rank < cur.rank) begin
                    tbl_d.slot[j].rank = tbl_q.slot[j].rank + RW'(1);
                end
            end
            nxt.rank        = '0;
            tbl_d.slot[sel] = nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tbl_q <= tbl_init();
        else        tbl_q <= tbl_d;
    end

    spf_burst #(.BW(BW), .DEGREE(DEGREE)) u_burst (
        .clk   (clk),
        .rst_n (rst_n),
        .ld    (ld),
        .base  (ld_base),
        .up    (ld_up),
        .ready (pf_ready),
        .valid (busy),
        .blk   (pf_blk)
    );

    assign pf_valid = busy;
    assign pf_addr  = {pf_blk, {OFS_W{1'b0}}};
endmodule

// File: rtl/stream_prefetcher_chk.sv
module stream_prefetcher_chk #(
    parameter int ADDR_W    = 32,
    parameter int BLK_BYTES = 64,
    parameter int DEGREE    = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_ready,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [ADDR_W-1:0] pf_addr
);
    localparam int OFS_W = $clog2(BLK_BYTES);
    localparam int CW    = $clog2(DEGREE + 1);

    logic [CW-1:0] beats_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) beats_q <= '0;
        else if (pf_valid && pf_ready)
            beats_q <= (beats_q == CW'(DEGREE - 1)) ? '0 : (beats_q + CW'(1));
    end

    // R8: a stalled prefetch keeps its address
    a_r8_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && !pf_ready |=> pf_valid && $stable(pf_addr));

    // R8: no demand access taken while a burst is pending
    a_r8_no_accept_in_burst: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> !acc_ready);

    // R8: a burst starts only right after an accepted access
    a_r8_burst_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pf_valid) |-> $past(acc_valid && acc_ready));

    // R2: prefetch addresses are block aligned
    a_r2_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid |-> (pf_addr[OFS_W-1:0] == '0));

    // R5: consecutive beats are one block apart
    a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready |=> !pf_valid
            || ((pf_addr - $past(pf_addr)) == ADDR_W'(BLK_BYTES))
            || (($past(pf_addr) - pf_addr) == ADDR_W'(BLK_BYTES)));

    // R5: a burst ends after exactly DEGREE beats
    a_r5_burst_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pf_valid) |-> (beats_q == '0));

    a_r5_burst_stop: assert property (@(posedge clk) disable iff (!rst_n)
        pf_valid && pf_ready && (beats_q == CW'(DEGREE - 1)) |=> !pf_valid);
endmodule

bind stream_prefetcher stream_prefetcher_chk #(
    .ADDR_W    (ADDR_W),
    .BLK_BYTES (BLK_BYTES),
    .DEGREE    (DEGREE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_ready (acc_ready),
    .pf_valid  (pf_valid),
    .pf_ready  (pf_ready),
    .pf_addr   (pf_addr)
);

// File: tb/stream_prefetcher_tb.sv
`timescale 1ns/1ps
module stream_prefetcher_tb;
    localparam int TB_DIST = 13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_ready;
    logic [31:0] acc_addr = '0;
    logic        pf_valid;
    logic        pf_ready = 1'b1;
    logic [31:0] pf_addr;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    stream_prefetcher #(.DIST(TB_DIST)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_valid),
        .acc_ready (acc_ready),
        .acc_addr  (acc_addr),
        .pf_valid  (pf_valid),
        .pf_ready  (pf_ready),
        .pf_addr   (pf_addr)
    );

    typedef struct packed {
        logic [31:0] blk;
        logic [5:0]  off;
        logic [2:0]  n;
        logic        up;
        logic [31:0] first;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{32'h100,  6'h03, 3'd0, 1'b1, 32'h0,    4'd9},  // R9 allocate, R2 offset
        '{32'h101,  6'h3F, 3'd0, 1'b1, 32'h0,    4'd3},  // R3 first sample
        '{32'h102,  6'h10, 3'd0, 1'b1, 32'h0,    4'd3},  // R3 confirm, end=0x106
        '{32'h103,  6'h00, 3'd4, 1'b1, 32'h107,  4'd5},  // R5 hit, R6 grow
        '{32'h105,  6'h21, 3'd4, 1'b1, 32'h10B,  4'd6},  // R6 slide, start=0x104
        '{32'h104,  6'h00, 3'd0, 1'b1, 32'h0,    4'd5},  // R5 strict low bound
        '{32'h105,  6'h00, 3'd4, 1'b1, 32'h10F,  4'd11}, // R11 lowest index wins
        '{32'h800,  6'h00, 3'd0, 1'b0, 32'h0,    4'd9},  // R9
        '{32'h7FF,  6'h00, 3'd0, 1'b0, 32'h0,    4'd7},  // R7
        '{32'h7FE,  6'h00, 3'd0, 1'b0, 32'h0,    4'd7},  // R7 end=0x7FA
        '{32'h7FD,  6'h00, 3'd4, 1'b0, 32'h7F9,  4'd7},  // R7 descending burst
        '{32'h2000, 6'h00, 3'd0, 1'b1, 32'h0,    4'd4},  // R4
        '{32'h2001, 6'h00, 3'd0, 1'b1, 32'h0,    4'd4},
        '{32'h1FFF, 6'h00, 3'd0, 1'b1, 32'h0,    4'd4},  // R4 disagreement
        '{32'h2002, 6'h00, 3'd0, 1'b1, 32'h0,    4'd4},
        '{32'h2003, 6'h00, 3'd0, 1'b1, 32'h0,    4'd4},
        '{32'h2004, 6'h00, 3'd0, 1'b1, 32'h0,    4'd4},
        '{32'h2005, 6'h00, 3'd4, 1'b1, 32'h2009, 4'd4},
        '{32'h3000, 6'h00, 3'd0, 1'b1, 32'h0,    4'd10}, // R10
        '{32'h3000, 6'h1F, 3'd0, 1'b1, 32'h0,    4'd10}, // R10 same block
        '{32'h3001, 6'h00, 3'd0, 1'b1, 32'h0,    4'd10},
        '{32'h3002, 6'h00, 3'd0, 1'b1, 32'h0,    4'd10},
        '{32'h3003, 6'h00, 3'd4, 1'b1, 32'h3007, 4'd10},
        '{32'h300A, 6'h00, 3'd0, 1'b1, 32'h0,    4'd5}   // R5 strict high bound
    };

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    endtask

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // drive one access, then check the burst it should cause (n beats)
    task automatic access_check(input logic [31:0] blk, input logic [5:0] off,
                                input int n, input logic up,
                                input logic [31:0] first, input string rq);
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = (blk << 6) | 32'(off);
        @(negedge clk);
        acc_valid = 1'b0;
        for (int k = 0; k < n; k++) begin
            logic [31:0] eb;
            eb = up ? (first + 32'(k)) : (first - 32'(k));
            chk(pf_valid == 1'b1, rq, "pf_valid in burst", 32'(pf_valid), 32'd1);
            chk(pf_addr == (eb << 6), rq, "pf_addr", pf_addr, eb << 6);
            @(negedge clk);
        end
        chk(pf_valid == 1'b0 && acc_ready == 1'b1, rq, "idle after access",
            {30'd0, pf_valid, acc_ready}, 32'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(acc_ready == 1'b1, "R1", "acc_ready in reset", 32'(acc_ready), 32'd1);
        chk(pf_valid == 1'b0, "R1", "pf_valid in reset", 32'(pf_valid), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            access_check(VECS[v].blk, VECS[v].off, int'(VECS[v].n), VECS[v].up,
                         VECS[v].first, $sformatf("R%0d", VECS[v].rq));
        end

        // R8 backpressure: stream at 0x4000, end 0x4006
        access_check(32'h4000, 6'h0, 0, 1'b1, 32'h0, "R8");
        access_check(32'h4001, 6'h0, 0, 1'b1, 32'h0, "R8");
        access_check(32'h4002, 6'h0, 0, 1'b1, 32'h0, "R8");
        pf_ready = 1'b0;
        @(negedge clk);
        acc_valid = 1'b1;
        acc_addr  = 32'h4003 << 6;
        @(negedge clk);
        acc_addr  = 32'h4004 << 6;   // held while burst pending: must not be taken
        for (int s = 0; s < 3; s++) begin
            chk(pf_valid && pf_addr == (32'h4007 << 6), "R8", "stalled address",
                pf_addr, 32'h4007 << 6);
            chk(acc_ready == 1'b0, "R8", "acc_ready during burst", 32'(acc_ready), 32'd0);
            @(negedge clk);
        end
        acc_valid = 1'b0;
        pf_ready  = 1'b1;
        for (int k = 0; k < 4; k++) begin
            chk(pf_valid && pf_addr == ((32'h4007 + 32'(k)) << 6), "R8", "drained beat",
                pf_addr, (32'h4007 + 32'(k)) << 6);
            @(negedge clk);
        end
        repeat (2) begin
            chk(pf_valid == 1'b0 && acc_ready == 1'b1, "R8", "no second burst",
                32'(pf_valid), 32'd0);
            @(negedge clk);
        end

        // R1 reset mid-run clears the table
        rst_n = 1'b0;
        @(negedge clk);
        chk(acc_ready == 1'b1 && pf_valid == 1'b0, "R1", "outputs in reset",
            {30'd0, acc_ready, pf_valid}, 32'd2);
        rst_n = 1'b1;
        access_check(32'h103, 6'h0, 0, 1'b1, 32'h0, "R1");

        // R9 replacement in a full table (after one more reset)
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            access_check(32'h1000 * 32'(i + 1), 6'h0, 0, 1'b1, 32'h0, "R9");
        end
        access_check(32'h1001, 6'h0, 0, 1'b1, 32'h0, "R9");   // touch oldest
        access_check(32'h9000, 6'h0, 0, 1'b1, 32'h0, "R9");   // reclaims entry of 0x2000
        access_check(32'h1002, 6'h0, 0, 1'b1, 32'h0, "R9");
        access_check(32'h1003, 6'h0, 4, 1'b1, 32'h1007, "R9"); // touched entry survived
        access_check(32'h9001, 6'h0, 0, 1'b1, 32'h0, "R9");
        access_check(32'h9002, 6'h0, 0, 1'b1, 32'h0, "R9");
        access_check(32'h9003, 6'h0, 4, 1'b1, 32'h9007, "R9");
        access_check(32'h2001, 6'h0, 0, 1'b1, 32'h0, "R9");
        access_check(32'h2002, 6'h0, 0, 1'b1, 32'h0, "R9");
        access_check(32'h2003, 6'h0, 0, 1'b1, 32'h0, "R9");   // evicted: no burst

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end
endmodule